// File: doc/BRIEF.md
# Crosstalk Glitch Detector Output Bank

This block is a bank of detector cells, one for each output of a combinational circuit under test. Each cell watches its output during a crosstalk self-test. The test runs in three steps for every stimulus pattern. First, a clear pulse empties the error detectors. Next, in the sensitization step, one input of the circuit under test is driven with a value and then with its complement. A cell whose output follows that toggle is marked as lying on a sensitized path. Finally, in the oscillation step, the same input receives a square wave while the bank samples every output at test-clock rate.

In the oscillation step, a cell that saw a transition on an output that was not marked sensitized has caught a pulse induced by coupling. The detector latches that event and keeps it until the next clear. Each cell reports its own flag. The bank also provides the OR of all cells, so that one line reports a fault anywhere on the outputs.

Glitches are modelled as sampled transitions. The capture clock and the detector clock are modelled as level enables on a single test clock.

Top module: `xt_glitch_bank`

## Requirements
- R1: A synchronous active-high `rst` clears every register. After a reset edge, `cell_err` is all zeros and `any_err` is 0.
- R2: While `mode_open` is 1 and `sample_en` is 1, each cell stores 1 in its sensitization bit if its output now differs from the last captured sample, and stores 0 otherwise. For a cell whose sensitization bit is 1, `cell_err` stays 0 whatever the detector holds.
- R3: For a cell whose sensitization bit is 0, a change between two consecutive captured samples raises `cell_err` two clock edges after the edge that captured the changed sample. This requires `det_mask` = 0 and `mode_open` = 0 in the cycle between those two edges.
- R4: A sample difference present in a cycle where `det_mask` is 1 is ignored. It never sets the detector.
- R5: Once set, a cell's error flag stays 1 until a clear, whatever the later samples are.
- R6: `det_clr` = 1 empties the detectors at that edge. `cell_err` follows one edge later.
- R7: `any_err` is 1 exactly when at least one bit of `cell_err` is 1, in every cycle.
- R8: While `sample_en` is 0, the captured samples hold, so changes on `cut_out` cannot reach the detectors.
- R9: The sensitization bit keeps its value in every cycle where `mode_open` is 0.
- R10: A sample difference present while `mode_open` is 1 never sets the detector, even when `det_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| cut_out | input | N_OUT | Outputs of the circuit under test |
| sample_en | input | 1 | Capture enable; shifts the two-stage sample pair |
| mode_open | input | 1 | Opens the sensitization latch |
| det_mask | input | 1 | 1 blocks detector sampling (detector clock high) |
| det_clr | input | 1 | Clears the error detectors |
| cell_err | output | N_OUT | Registered per-cell error flag |
| any_err | output | 1 | Registered OR of all cell flags |

## Verification
The bench builds the bank with N_OUT = 4. Four outputs are enough to place two sensitized cells and two free cells in one pattern. With that split, masking, detection and the ignored windows can each be seen on a different bit of the same port. A glitch on one free cell is caught while another free cell's glitch falls in a masked window. The bench also re-latches a cell from sensitized back to free and then catches an error on it.

// File: rtl/xt_glitch_pkg.sv
package xt_glitch_pkg;

  // Two consecutive captured samples of one output.
  typedef struct packed {
    logic newer;
    logic older;
  } xt_pair_t;

  localparam int unsigned XT_ERR_LATENCY = 2;

endpackage

// File: rtl/xt_sample_pair.sv
module xt_sample_pair
  import xt_glitch_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sample_en,
  input  logic     d,
  output xt_pair_t pair_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q <= '0;
    end else if (sample_en) begin
      pair_q.newer <= d;
      pair_q.older <= pair_q.newer;
    end
  end

  AST_PAIR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(pair_q)); // R8

endmodule

// File: rtl/xt_sense_latch.sv
module xt_sense_latch (
  input  logic clk,
  input  logic rst,
  input  logic mode_open,
  input  logic sample_en,
  input  logic live,
  input  logic held,
  output logic sens_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sens_q <= 1'b0;
    end else if (mode_open && sample_en) begin
      sens_q <= live ^ held;
    end
  end

  AST_SENSE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !mode_open |=> $stable(sens_q)); // R9

endmodule

// File: rtl/xt_sticky_det.sv
module xt_sticky_det (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic det_mask,
  input  logic mode_open,
  input  logic diff,
  output logic hit_q
);

  logic sample_window;

  assign sample_window = !det_mask && !mode_open;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hit_q <= 1'b0;
    end else if (sample_window && diff) begin
      hit_q <= 1'b1;
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> !hit_q); // R6

  AST_HIT_STICKS: assert property (@(posedge clk) disable iff (rst)
    hit_q && !clr |=> hit_q); // R5

  AST_MASK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !hit_q && !clr && det_mask |=> !hit_q); // R4

  AST_OPEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !hit_q && !clr && mode_open |=> !hit_q); // R10

endmodule

// File: rtl/xt_glitch_bank.sv
module xt_glitch_bank
  import xt_glitch_pkg::*;
#(
  parameter int unsigned N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] cut_out,
  input  logic             sample_en,
  input  logic             mode_open,
  input  logic             det_mask,
  input  logic             det_clr,
  output logic [N_OUT-1:0] cell_err,
  output logic             any_err
);

  localparam int unsigned LAST = N_OUT - 1;

  xt_pair_t   pair   [N_OUT];
  logic [LAST:0] sens;
  logic [LAST:0] hit;
  logic [LAST:0] raw_err;

  for (genvar i = 0; i < N_OUT; i++) begin : g_cell
    xt_sample_pair u_pair (
      .clk       (clk),
      .rst       (rst),
      .sample_en (sample_en),
      .d         (cut_out[i]),
      .pair_q    (pair[i])
    );

    xt_sense_latch u_sense (
      .clk       (clk),
      .rst       (rst),
      .mode_open (mode_open),
      .sample_en (sample_en),
      .live      (cut_out[i]),
      .held      (pair[i].newer),
      .sens_q    (sens[i])
    );

    xt_sticky_det u_det (
      .clk       (clk),
      .rst       (rst),
      .clr       (det_clr),
      .det_mask  (det_mask),
      .mode_open (mode_open),
      .diff      (pair[i].newer ^ pair[i].older),
      .hit_q     (hit[i])
    );

    assign raw_err[i] = hit[i] && !sens[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        cell_err[i] <= 1'b0;
      end else begin
        cell_err[i] <= raw_err[i];
      end
    end

    AST_SENS_MASKS: assert property (@(posedge clk) disable iff (rst)
      sens[i] |=> !cell_err[i]); // R2

    AST_FREE_REPORTS: assert property (@(posedge clk) disable iff (rst)
      !sens[i] && hit[i] |=> cell_err[i]); // R3
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_err <= 1'b0;
    end else begin
      any_err <= |raw_err;
    end
  end

  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (rst)
    any_err == (|cell_err)); // R7

endmodule

// File: tb/sim_xt_glitch_bank.sv
module sim_xt_glitch_bank;

  localparam int unsigned N = 4;
  localparam int unsigned ROWS = 28;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] cut_out = '0;
  logic         sample_en = 1'b0;
  logic         mode_open = 1'b0;
  logic         det_mask = 1'b1;
  logic         det_clr = 1'b0;
  logic [N-1:0] cell_err;
  logic         any_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  xt_glitch_bank #(.N_OUT(N)) u0 (
    .clk       (clk),
    .rst       (rst),
    .cut_out   (cut_out),
    .sample_en (sample_en),
    .mode_open (mode_open),
    .det_mask  (det_mask),
    .det_clr   (det_clr),
    .cell_err  (cell_err),
    .any_err   (any_err)
  );

  // Row layout: {cut_out[3:0], sample_en, mode_open, det_mask, det_clr, expected cell_err[3:0]}
  // The inputs are applied before an edge; the expected value holds after that edge.
  localparam logic [11:0] VEC [ROWS] = '{
    12'b0000_1011_0000, // 0  clear
    12'b0000_1110_0000, // 1  sensitize, first value
    12'b0011_1110_0000, // 2  complement: bits 0,1 follow
    12'b0011_1010_0000, // 3  close latch
    12'b0000_1000_0000, // 4  oscillate
    12'b0011_1000_0000, // 5
    12'b0000_1000_0000, // 6  sensitized toggling is masked
    12'b0100_1000_0000, // 7  glitch on bit 2
    12'b0000_1000_0000, // 8
    12'b0000_1000_0100, // 9  reported
    12'b0000_1000_0100, // 10 sticky
    12'b1000_1010_0100, // 11 glitch on bit 3 under mask
    12'b0000_1010_0100, // 12
    12'b0000_1010_0100, // 13
    12'b0000_1000_0100, // 14 bit 3 never set
    12'b0000_1001_0100, // 15 clear
    12'b0000_1000_0000, // 16 flag drops
    12'b1000_0000_0000, // 17 capture off
    12'b0000_0000_0000, // 18
    12'b1000_0000_0000, // 19
    12'b0000_1000_0000, // 20
    12'b0100_1100_0000, // 21 latch open, detector unmasked
    12'b0100_1100_0000, // 22 difference ignored, bit 2 ends free
    12'b0100_1000_0000, // 23
    12'b0100_1000_0000, // 24
    12'b0101_1000_0000, // 25 glitch on bit 0, now free
    12'b0100_1000_0000, // 26
    12'b0100_1000_0001  // 27 reported
  };

  function automatic string row_tag(int r);
    if (r <= 5)  return "R2";
    if (r <= 8)  return "R9";
    if (r == 9)  return "R3";
    if (r == 10) return "R5";
    if (r <= 14) return "R4";
    if (r <= 16) return "R6";
    if (r <= 20) return "R8";
    if (r <= 24) return "R10";
    return "R3";
  endfunction

  task automatic check_out(string tag, logic [N-1:0] exp_cells);
    checks++;
    if (cell_err !== exp_cells) begin
      fails++;
      $display("FAIL %s cell_err actual=%b expected=%b", tag, cell_err, exp_cells);
    end
    checks++;
    if (any_err !== (|exp_cells)) begin
      fails++;
      $display("FAIL R7 any_err actual=%b expected=%b (%s)", any_err, |exp_cells, tag);
    end
  endtask

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check_out("R1", '0);
    rst = 1'b0;

    for (int r = 0; r < ROWS; r++) begin
      {cut_out, sample_en, mode_open, det_mask, det_clr} = VEC[r][11:4];
      @(posedge clk);
      #1;
      check_out(row_tag(r), VEC[r][3:0]);
    end

    // R1: reset in mid-run with a flag set
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_out("R1", '0);
    rst = 1'b0;
    {sample_en, mode_open, det_mask, det_clr} = 4'b1000;
    cut_out = '0;
    repeat (3) @(posedge clk);
    #1;
    check_out("R1", '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule